// File: doc/BRIEF.md
# Address-Tagged Coherent Register File

This block is a small register file in which every register can be tied to one word of data memory. A register that is tied to an address has an address tag and an active flag, and it holds the current value of that memory word. This lets a compiler keep a variable in a register even when a pointer elsewhere might also reach it. The registers are grouped into sets of four ways. Every processor load or store is compared against the tags of a single set only, and the two low bits of the word address choose that set. A load that matches is answered from the register. A store that matches writes the register. Either way, the access never reaches backing memory.

A register write does not go to memory straight away. It marks the register dirty, and the value is written back later: when the register is rebound, when it is unbound, or when a flush command runs. Binding a register to an address reads that word once from memory to fill the register. An optional trap mode turns every matching processor access into a trap pulse instead of serving it. One sequencer drives the backing-memory port, so the block handles one outstanding memory transaction at a time. While it is busy, it stalls both the command port and the processor port.

The command and processor request ports are valid/ready. A request is taken on a clock edge where both valid and ready are high. The requester must hold valid and its fields steady until then. Ready falls whenever the block is busy, and processor ready is also low while a command is offered, because commands win. The backing-memory port is request/acknowledge. The request and its fields stay constant until the cycle in which the acknowledge is seen high.

Top module: `crf_regfile`

## Requirements
- R1: After reset, all registers are unbound and hold zero, `busy` and `mem_req` are low, and both `cmd_ready` and `cpu_ready` are high.
- R2: A bind (`cmd_op`=0) is rejected when the address set `cmd_addr[1:0]` differs from the register's set `cmd_idx[3:2]`. A rejected bind pulses `cmd_err` for one cycle after acceptance, creates no memory traffic and leaves the register unchanged.
- R3: An accepted bind performs exactly one backing-memory read of the bound address. When it is acknowledged, the register holds the read data and is clean. `busy` is high meanwhile, and the memory request stays stable until acknowledged.
- R4: A processor load that matches an active tag in its set returns the register's value with `cpu_rsp_valid` one cycle after acceptance, and causes no backing-memory read.
- R5: A processor store that matches an active tag writes the register, is acknowledged one cycle after acceptance, and causes no backing-memory write.
- R6: A register-port write to a bound register marks it dirty and causes no memory write. Later processor loads of that address see the written value.
- R7: Rebinding or unbinding (`cmd_op`=1) a dirty register first writes its current value to its old address. A clean unbind makes no memory traffic. After an unbind, accesses to the old address go to memory.
- R8: A bind to an address already held by another active register of the same set is rejected with `cmd_err`, so at most one way matches any access.
- R9: With `trap_mode` high, a matching processor access pulses `trap` one cycle after acceptance instead of `cpu_rsp_valid`. It changes no register and makes no memory traffic. Non-matching accesses are served normally.
- R10: A processor access that matches nothing is forwarded to backing memory. A load returns the memory data, and a store writes memory. Either is answered by one `cpu_rsp_valid` pulse.
- R11: A flush (`cmd_op`=2) writes back every bound dirty register in ascending register index order. It leaves all of them bound and clean, so an immediate second flush writes nothing.
- R12: While `busy` is high, both `cmd_ready` and `cpu_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_mode | input | 1 | Turn matching processor accesses into traps |
| rf_we | input | 1 | Register-port write enable |
| rf_idx | input | 4 | Register-port index |
| rf_wdata | input | 32 | Register-port write data |
| rf_rdata | output | 32 | Register-port read data (combinational) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 bind, 1 unbind, 2 flush, 3 no-op |
| cmd_idx | input | 4 | Target register of bind/unbind |
| cmd_addr | input | 16 | Word address for bind |
| cmd_err | output | 1 | One-cycle pulse: bind rejected |
| cpu_valid | input | 1 | Processor request offered |
| cpu_ready | output | 1 | Processor request can be taken |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 32 | Processor store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rdata | output | 32 | Load result, valid with the response |
| trap | output | 1 | One-cycle trap pulse |
| mem_req | output | 1 | Backing-memory request |
| mem_we | output | 1 | Backing-memory write |
| mem_addr | output | 16 | Backing-memory word address |
| mem_wdata | output | 32 | Backing-memory write data |
| mem_ack | input | 1 | Backing-memory acknowledge |
| mem_rdata | input | 32 | Backing-memory read data |
| busy | output | 1 | Memory transaction or flush in progress |

## Verification
Results from the block's registers alone are due one cycle after acceptance: a hit's `cpu_rsp_valid`, `trap` and `cmd_err`. The bench samples these at the first falling edge after the accepting rising edge and checks that the latency is exactly one. Results that need memory — fills, write-backs, forwarded misses and flush order — are due only once the acknowledge has been seen. The bench therefore waits at falling edges until `busy` drops, and then compares register contents, the model memory, and its read and write counters and write-address log.

// File: rtl/crf_pkg.sv
package crf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_FWD,
    ST_FLUSH
  } crf_state_e;

  typedef enum logic [1:0] {
    OP_BIND   = 2'd0,
    OP_UNBIND = 2'd1,
    OP_FLUSH  = 2'd2,
    OP_NONE   = 2'd3
  } crf_op_e;
endpackage

// File: rtl/crf_way_match.sv
module crf_way_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][ADDR_W-1:0] tags,
  input  logic [WAYS-1:0]             act,
  input  logic [ADDR_W-1:0]           addr,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = act[w] && (tags[w] == addr);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
endmodule

// File: rtl/crf_first_set.sv
module crf_first_set #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
  end
endmodule

// File: rtl/crf_regfile.sv
module crf_regfile
  import crf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int NREG  = SETS * WAYS,
  localparam int IDX_W = $clog2(NREG),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_mode,
  input  logic              rf_we,
  input  logic [IDX_W-1:0]  rf_idx,
  input  logic [DATA_W-1:0] rf_wdata,
  output logic [DATA_W-1:0] rf_rdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_err,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              trap,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy
);
  logic [DATA_W-1:0] data_q [NREG];
  logic [ADDR_W-1:0] tag_q  [NREG];
  logic [NREG-1:0]   act_q, dirty_q;

  crf_state_e        state_q;
  logic [1:0]        op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  // per-set views for the processor lookup and the bind duplicate check
  logic [SET_W-1:0]             cpu_set, cmd_set;
  logic [WAYS-1:0][ADDR_W-1:0]  cpu_tags, bnd_tags;
  logic [WAYS-1:0]              cpu_act, bnd_act, cpu_hit_vec, bnd_hit_vec;
  logic                         cpu_hit, bnd_dup;
  logic [WAY_W-1:0]             cpu_way, bnd_way;
  logic [IDX_W-1:0]             cpu_hit_idx;
  logic                         set_bad;
  logic                         dirty_any;
  logic [IDX_W-1:0]             dirty_idx;

  assign cpu_set = cpu_addr[SET_W-1:0];
  assign cmd_set = cmd_addr[SET_W-1:0];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cpu_tags[w] = tag_q[{cpu_set, WAY_W'(w)}];
      cpu_act[w]  = act_q[{cpu_set, WAY_W'(w)}];
      bnd_tags[w] = tag_q[{cmd_set, WAY_W'(w)}];
      bnd_act[w]  = act_q[{cmd_set, WAY_W'(w)}] && (WAY_W'(w) != cmd_idx[WAY_W-1:0]);
    end
  end

  crf_way_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) i_cpu_match (
    .tags(cpu_tags), .act(cpu_act), .addr(cpu_addr),
    .hit_vec(cpu_hit_vec), .hit(cpu_hit), .hit_way(cpu_way));

  crf_way_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) i_bind_match (
    .tags(bnd_tags), .act(bnd_act), .addr(cmd_addr),
    .hit_vec(bnd_hit_vec), .hit(bnd_dup), .hit_way(bnd_way));

  crf_first_set #(.N(NREG)) i_flush_pick (
    .vec(act_q & dirty_q), .any(dirty_any), .idx(dirty_idx));

  assign cpu_hit_idx = {cpu_set, cpu_way};
  assign set_bad     = cmd_idx[IDX_W-1:WAY_W] != cmd_set;

  assign busy      = state_q != ST_IDLE;
  assign cmd_ready = !busy;
  assign cpu_ready = !busy && !cmd_valid;
  assign rf_rdata  = data_q[rf_idx];
  assign mem_req   = state_q inside {ST_WBACK, ST_FILL, ST_FWD};
  assign mem_we    = (state_q == ST_WBACK) || ((state_q == ST_FWD) && we_q);
  assign mem_addr  = (state_q == ST_WBACK) ? tag_q[idx_q] : addr_q;
  assign mem_wdata = (state_q == ST_WBACK) ? data_q[idx_q] : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end
      act_q         <= '0;
      dirty_q       <= '0;
      state_q       <= ST_IDLE;
      op_q          <= OP_NONE;
      idx_q         <= '0;
      addr_q        <= '0;
      we_q          <= 1'b0;
      wdata_q       <= '0;
      cmd_err       <= 1'b0;
      trap          <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rdata     <= '0;
    end else begin
      cmd_err       <= 1'b0;
      trap          <= 1'b0;
      cpu_rsp_valid <= 1'b0;

      if (rf_we) begin
        data_q[rf_idx] <= rf_wdata;
        if (act_q[rf_idx]) dirty_q[rf_idx] <= 1'b1;
      end

      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= cmd_op;
            idx_q  <= cmd_idx;
            addr_q <= cmd_addr;
            case (cmd_op)
              OP_BIND: begin
                if (set_bad || bnd_dup) cmd_err <= 1'b1;
                else if (act_q[cmd_idx] && dirty_q[cmd_idx]) state_q <= ST_WBACK;
                else state_q <= ST_FILL;
              end
              OP_UNBIND: begin
                if (act_q[cmd_idx] && dirty_q[cmd_idx]) state_q <= ST_WBACK;
                else begin
                  act_q[cmd_idx]   <= 1'b0;
                  dirty_q[cmd_idx] <= 1'b0;
                end
              end
              OP_FLUSH: state_q <= ST_FLUSH;
              default: ;
            endcase
          end else if (cpu_valid) begin
            if (cpu_hit && trap_mode) begin
              trap <= 1'b1;
            end else if (cpu_hit) begin
              cpu_rsp_valid <= 1'b1;
              if (cpu_we) begin
                data_q[cpu_hit_idx]  <= cpu_wdata;
                dirty_q[cpu_hit_idx] <= 1'b1;
              end else begin
                cpu_rdata <= data_q[cpu_hit_idx];
              end
            end else begin
              addr_q  <= cpu_addr;
              we_q    <= cpu_we;
              wdata_q <= cpu_wdata;
              state_q <= ST_FWD;
            end
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            dirty_q[idx_q] <= 1'b0;
            case (op_q)
              OP_BIND:  state_q <= ST_FILL;
              OP_FLUSH: state_q <= ST_FLUSH;
              default: begin
                act_q[idx_q] <= 1'b0;
                state_q      <= ST_IDLE;
              end
            endcase
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            data_q[idx_q]  <= mem_rdata;
            tag_q[idx_q]   <= addr_q;
            act_q[idx_q]   <= 1'b1;
            dirty_q[idx_q] <= 1'b0;
            state_q        <= ST_IDLE;
          end
        end
        ST_FWD: begin
          if (mem_ack) begin
            cpu_rsp_valid <= 1'b1;
            if (!we_q) cpu_rdata <= mem_rdata;
            state_q <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (dirty_any) begin
            idx_q   <= dirty_idx;
            state_q <= ST_WBACK;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cpu_ready && !cmd_ready)); // R12
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> $onehot0(cpu_hit_vec)); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !mem_req); // R2
  AST_TRAP_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !cpu_rsp_valid); // R9
  AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_hit) |=> !mem_req); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
endmodule

// File: tb/test_crf_regfile.sv
`timescale 1ns/1ps
module test_crf_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_mode = 1'b0;
  logic        rf_we = 1'b0;
  logic [3:0]  rf_idx = '0;
  logic [31:0] rf_wdata = '0;
  logic [31:0] rf_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_idx = '0;
  logic [15:0] cmd_addr = '0;
  logic        cmd_err;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rdata;
  logic        trap;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [15:0] rlast = '0;
  logic [15:0] wlog [32];
  logic [31:0] mem [256];

  always #2.5 clk = ~clk;

  crf_regfile i_crf_regfile (.*);

  // backing memory: acknowledge one cycle after a request is seen
  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'hA000_0000 + 32'(a);
    for (int a = 0; a < 32; a++) wlog[a] = '0;
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          wlog[wr_cnt[4:0]]  <= mem_addr;
          wr_cnt             <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem[mem_addr[7:0]];
          rlast     <= mem_addr;
          rd_cnt    <= rd_cnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [3:0] idx, input logic [15:0] addr,
                        output logic err, output logic bsy, output logic rdy);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_addr = addr;
    @(posedge clk);
    @(negedge clk);
    err = cmd_err; bsy = busy; rdy = cmd_ready | cpu_ready;
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic cpu_acc(input logic we, input logic [15:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output logic got_rsp, output logic got_trap,
                         output int lat);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid && !trap && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata; got_rsp = cpu_rsp_valid; got_trap = trap;
    wait_idle();
  endtask

  task automatic rf_write(input logic [3:0] idx, input logic [31:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_idx = idx; rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic rf_read(input logic [3:0] idx, output logic [31:0] v);
    rf_idx = idx;
    #0.1;
    v = rf_rdata;
  endtask

  logic        e, b, r, rs, tp;
  logic [31:0] d;
  int          lat, rc, wc;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 ready", {30'd0, cmd_ready, cpu_ready}, 32'd3);
    rf_read(4'd0, d);
    chk("R1 reg0", d, 0);
  endtask

  task automatic t_bind_fill();
    rc = rd_cnt;
    do_cmd(2'd0, 4'd5, 16'h0011, e, b, r);
    chk("R3 busy during fill", 32'(b), 1);
    chk("R12 ports stalled", 32'(r), 0);
    chk("R3 no err", 32'(e), 0);
    chk("R3 one read", 32'(rd_cnt), 32'(rc + 1));
    chk("R3 read addr", 32'(rlast), 32'h11);
    rf_read(4'd5, d);
    chk("R3 filled", d, 32'hA000_0011);
  endtask

  task automatic t_reject();
    rc = rd_cnt; wc = wr_cnt;
    do_cmd(2'd0, 4'd6, 16'h0022, e, b, r);
    chk("R2 err", 32'(e), 1);
    chk("R2 no traffic", 32'(rd_cnt + wr_cnt), 32'(rc + wc));
    rf_read(4'd6, d);
    chk("R2 reg untouched", d, 0);
  endtask

  task automatic t_dup();
    rc = rd_cnt; wc = wr_cnt;
    do_cmd(2'd0, 4'd6, 16'h0011, e, b, r);
    chk("R8 dup err", 32'(e), 1);
    chk("R8 no traffic", 32'(rd_cnt + wr_cnt), 32'(rc + wc));
  endtask

  task automatic t_hit_load();
    rc = rd_cnt;
    cpu_acc(1'b0, 16'h0011, 0, d, rs, tp, lat);
    chk("R4 data", d, 32'hA000_0011);
    chk("R4 latency", 32'(lat), 1);
    chk("R4 no read", 32'(rd_cnt), 32'(rc));
  endtask

  task automatic t_hit_store();
    wc = wr_cnt;
    cpu_acc(1'b1, 16'h0011, 32'hDEAD_0001, d, rs, tp, lat);
    chk("R5 ack", {30'd0, rs, 1'b0} | 32'(lat), 32'h3);
    rf_read(4'd5, d);
    chk("R5 reg", d, 32'hDEAD_0001);
    chk("R5 no write", 32'(wr_cnt), 32'(wc));
    chk("R5 mem stale ok", mem[8'h11], 32'hA000_0011);
  endtask

  task automatic t_miss();
    rc = rd_cnt; wc = wr_cnt;
    cpu_acc(1'b0, 16'h0030, 0, d, rs, tp, lat);
    chk("R10 load data", d, 32'hA000_0030);
    chk("R10 load read", 32'(rd_cnt), 32'(rc + 1));
    cpu_acc(1'b1, 16'h0034, 32'h0000_5555, d, rs, tp, lat);
    chk("R10 store rsp", 32'(rs), 1);
    chk("R10 store mem", mem[8'h34], 32'h0000_5555);
    chk("R10 store write", 32'(wr_cnt), 32'(wc + 1));
  endtask

  task automatic t_rf_write();
    do_cmd(2'd0, 4'd0, 16'h0040, e, b, r);
    wc = wr_cnt;
    rf_write(4'd0, 32'hBEEF_0000);
    chk("R6 no write", 32'(wr_cnt), 32'(wc));
    cpu_acc(1'b0, 16'h0040, 0, d, rs, tp, lat);
    chk("R6 load sees reg", d, 32'hBEEF_0000);
    chk("R6 mem untouched", mem[8'h40], 32'hA000_0040);
  endtask

  task automatic t_rebind();
    rc = rd_cnt; wc = wr_cnt;
    do_cmd(2'd0, 4'd5, 16'h0015, e, b, r);
    chk("R7 wb value", mem[8'h11], 32'hDEAD_0001);
    chk("R7 wb addr", 32'(wlog[wc[4:0]]), 32'h11);
    chk("R7 traffic", 32'(rd_cnt + wr_cnt), 32'(rc + wc + 2));
    rf_read(4'd5, d);
    chk("R7 refilled", d, 32'hA000_0015);
    rc = rd_cnt; wc = wr_cnt;
    do_cmd(2'd1, 4'd5, 16'h0000, e, b, r);
    chk("R7 clean unbind quiet", 32'(rd_cnt + wr_cnt), 32'(rc + wc));
    cpu_acc(1'b0, 16'h0015, 0, d, rs, tp, lat);
    chk("R7 unbound goes to mem", 32'(rd_cnt), 32'(rc + 1));
  endtask

  task automatic t_trap();
    do_cmd(2'd0, 4'd9, 16'h0022, e, b, r);
    trap_mode = 1'b1;
    rc = rd_cnt; wc = wr_cnt;
    cpu_acc(1'b1, 16'h0022, 32'h1234_5678, d, rs, tp, lat);
    chk("R9 trap", {30'd0, tp, rs}, 32'h2);
    chk("R9 latency", 32'(lat), 1);
    rf_read(4'd9, d);
    chk("R9 reg unchanged", d, 32'hA000_0022);
    chk("R9 no traffic", 32'(rd_cnt + wr_cnt), 32'(rc + wc));
    cpu_acc(1'b0, 16'h0032, 0, d, rs, tp, lat);
    chk("R9 miss served", {d[7:0], 6'd0, tp, rs}, {8'h32, 8'h01});
    trap_mode = 1'b0;
  endtask

  task automatic t_flush();
    rf_write(4'd9, 32'h0000_0099);
    do_cmd(2'd0, 4'd13, 16'h0043, e, b, r);
    rf_write(4'd13, 32'h0000_1313);
    wc = wr_cnt;
    do_cmd(2'd2, 4'd0, 16'h0000, e, b, r);
    chk("R11 count", 32'(wr_cnt), 32'(wc + 3));
    chk("R11 first", 32'(wlog[wc[4:0]]), 32'h40);
    chk("R11 second", 32'(wlog[5'(wc + 1)]), 32'h22);
    chk("R11 third", 32'(wlog[5'(wc + 2)]), 32'h43);
    chk("R11 value", mem[8'h22], 32'h0000_0099);
    wc = wr_cnt;
    do_cmd(2'd2, 4'd0, 16'h0000, e, b, r);
    chk("R11 clean after", 32'(wr_cnt), 32'(wc));
    rc = rd_cnt;
    cpu_acc(1'b0, 16'h0022, 0, d, rs, tp, lat);
    chk("R11 still bound", d, 32'h0000_0099);
    chk("R11 hit no read", 32'(rd_cnt), 32'(rc));
  endtask

  task automatic t_unbind_dirty();
    rf_write(4'd13, 32'h0000_7777);
    rc = rd_cnt; wc = wr_cnt;
    do_cmd(2'd1, 4'd13, 16'h0000, e, b, r);
    chk("R7 dirty unbind wb", mem[8'h43], 32'h0000_7777);
    chk("R7 dirty unbind one write", 32'(wr_cnt), 32'(wc + 1));
    cpu_acc(1'b0, 16'h0043, 0, d, rs, tp, lat);
    chk("R7 miss after unbind", d, 32'h0000_7777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bind_fill();
    t_reject();
    t_dup();
    t_hit_load();
    t_hit_store();
    t_miss();
    t_rf_write();
    t_rebind();
    t_trap();
    t_flush();
    t_unbind_dirty();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule